// File: doc/BRIEF.md
# Fractional-Capable Baud Rate Generator

This block turns the system clock into the two timing strobes an asynchronous serial port needs: an oversampling strobe at sixteen times the bit rate, and a bit strobe that marks every sixteenth oversampling strobe. Both strobes are one clock cycle wide. The block has no bus of its own. Configuration arrives as plain level inputs that a register file elsewhere holds: a run enable, a prescaler select, a fractional-mode enable, a 13-bit reload value and an 8-bit fraction step.

The reload counter is driven by one of two source tick generators. The integer prescaler divides the clock by 2 or by 3. The fractional accumulator adds the step to an 8-bit sum on every clock and ticks on each carry out, so its average rate is step/256 of the clock. The reload counter counts source ticks down from the reload value and issues an oversampling strobe each time it passes zero. A 4-bit phase counter then derives the bit strobe. Clearing the run enable parks every counter. The next run therefore starts from a clean state with a full-length first period.

Top module: `sbg_baud_gen`

## Requirements
- R1: While `run_en` is 0, `ovs_tick` and `bit_tick` stay 0 and all internal counters are held at their start values.
- R2: With `frac_en`=0, the source tick comes from the integer prescaler. Counting the first cycle with `run_en`=1 as cycle 1, a source tick occurs in every cycle k where k mod D = 0. D is 2 when `pre_sel`=0 and 3 when `pre_sel`=1.
- R3: With `frac_en`=1, the fractional accumulator supplies the source tick, and `pre_sel` has no effect on the strobes.
- R4: In fractional mode a source tick occurs in cycle k exactly when floor(k·S/256) > floor((k−1)·S/256), where S is `frac_step`. With S=0 no tick ever occurs.
- R5: With reload value N, `ovs_tick` is a single-cycle strobe on the source tick that completes each group of N+1 source ticks. That is, it occurs when the number of source ticks since the run began becomes a multiple of N+1.
- R6: A change of `reload_val` while running does not alter the period in progress. The new value is used from the next reload onward.
- R7: `bit_tick` is asserted together with every 16th `ovs_tick` counted from the start of the run, and never at any other time.
- R8: The 16-strobe phase is cleared whenever `run_en` is 0, so the first bit strobe of a new run falls on its 16th oversampling strobe.
- R9: After `run_en` goes 0 and back to 1, even for a single cycle, the first oversampling period is a full N+1 source ticks. N is the value of `reload_val` in the last stopped cycle.
- R10: While `rst_n` is low (asynchronous, active low), both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Generator run enable; 0 stops and clears the counters |
| pre_sel | input | 1 | Prescaler select: 0 divides by 2, 1 divides by 3 |
| frac_en | input | 1 | 1 selects the fractional accumulator as the tick source |
| reload_val | input | 13 | Reload value N; the oversample period is N+1 source ticks |
| frac_step | input | 8 | Fractional step S added to the accumulator each clock |
| ovs_tick | output | 1 | Single-cycle 16x oversampling strobe |
| bit_tick | output | 1 | Single-cycle bit strobe on every 16th oversampling strobe |

## Verification
A corrupted prescaler or accumulator state moves the very next oversampling strobe by one or more clocks, which shows within N+1 source ticks of the fault. A wrong reload counter value shortens or stretches the current period, and a wrong load at restart shows on the first strobe after run goes high. A phase counter that is not cleared moves the bit strobe away from the 16th oversampling strobe of the run. That error appears only after sixteen strobes, so the stimulus runs each configuration long enough to reach several bit strobes and stops runs at arbitrary points mid-period.

// File: rtl/sbg_pkg.sv
package sbg_pkg;

  // Prescaler state is wide enough for divide-by-3.
  localparam int unsigned PRE_CNT_W = 2;

  typedef logic [PRE_CNT_W-1:0] pre_cnt_t;

  // Last count value of the prescaler for the selected divide ratio.
  function automatic pre_cnt_t pre_last(input logic sel);
    return sel ? pre_cnt_t'(2) : pre_cnt_t'(1);
  endfunction

endpackage

// File: rtl/sbg_prescaler.sv
module sbg_prescaler
  import sbg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic sel,
  output logic tick
);

  pre_cnt_t cnt_q;
  pre_cnt_t last;

  always_comb begin
    last = pre_last(sel);
    tick = run && (cnt_q >= last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + pre_cnt_t'(1);
    end
  end

endmodule

// File: rtl/sbg_frac_acc.sv
module sbg_frac_acc #(
  parameter int unsigned FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              enable,
  input  logic [FRAC_W-1:0] step,
  output logic              tick
);

  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  // Accumulator sum with the carry out in the top bit.
  function automatic logic [FRAC_W:0] frac_add(input logic [FRAC_W-1:0] a,
                                               input logic [FRAC_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  always_comb begin
    sum  = frac_add(acc_q, step);
    tick = run && enable && sum[FRAC_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (!(run && enable)) begin
      acc_q <= '0;
    end else begin
      acc_q <= sum[FRAC_W-1:0];
    end
  end

endmodule

// File: rtl/sbg_reload_ctr.sv
module sbg_reload_ctr #(
  parameter int unsigned RLD_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             src_tick,
  input  logic [RLD_W-1:0] reload,
  output logic             ovs_tick,
  output logic [RLD_W-1:0] cnt
);

  logic [RLD_W-1:0] cnt_q;
  logic             at_zero;

  always_comb begin
    at_zero  = (cnt_q == '0);
    ovs_tick = run && src_tick && at_zero;
    cnt      = cnt_q;
  end

  // While stopped the counter tracks the reload value, so a run starts full length.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= reload;
    end else if (src_tick) begin
      cnt_q <= at_zero ? reload : (cnt_q - {{(RLD_W-1){1'b0}}, 1'b1});
    end
  end

endmodule

// File: rtl/sbg_phase_ctr.sv
module sbg_phase_ctr #(
  parameter int unsigned PH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            ovs_tick,
  output logic            bit_tick,
  output logic [PH_W-1:0] phase
);

  logic [PH_W-1:0] ph_q;

  always_comb begin
    bit_tick = ovs_tick && (ph_q == '1);
    phase    = ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else if (!run) begin
      ph_q <= '0;
    end else if (ovs_tick) begin
      ph_q <= ph_q + {{(PH_W-1){1'b0}}, 1'b1};
    end
  end

endmodule

// File: rtl/sbg_baud_gen.sv
module sbg_baud_gen #(
  parameter int unsigned RLD_W    = 13,
  parameter int unsigned FRAC_W   = 8,
  parameter int unsigned PH_W     = 4,
  parameter bit          USE_FRAC = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              pre_sel,
  input  logic              frac_en,
  input  logic [RLD_W-1:0]  reload_val,
  input  logic [FRAC_W-1:0] frac_step,
  output logic              ovs_tick,
  output logic              bit_tick
);

  // Internal events, named for the checker.
  logic             pre_tick;
  logic             frac_tick;
  logic             src_tick;
  logic [RLD_W-1:0] rld_cnt;
  logic [PH_W-1:0]  phase;

  sbg_prescaler u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_en),
    .sel   (pre_sel),
    .tick  (pre_tick)
  );

  generate
    if (USE_FRAC) begin : g_frac
      sbg_frac_acc #(.FRAC_W(FRAC_W)) u_frac (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_en),
        .enable (frac_en),
        .step   (frac_step),
        .tick   (frac_tick)
      );
    end else begin : g_nofrac
      assign frac_tick = 1'b0;
    end
  endgenerate

  assign src_tick = (USE_FRAC && frac_en) ? frac_tick : pre_tick;

  sbg_reload_ctr #(.RLD_W(RLD_W)) u_rld (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_en),
    .src_tick (src_tick),
    .reload   (reload_val),
    .ovs_tick (ovs_tick),
    .cnt      (rld_cnt)
  );

  sbg_phase_ctr #(.PH_W(PH_W)) u_ph (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_en),
    .ovs_tick (ovs_tick),
    .bit_tick (bit_tick),
    .phase    (phase)
  );

endmodule

// File: rtl/sbg_baud_gen_chk.sv
module sbg_baud_gen_chk #(
  parameter int unsigned RLD_W  = 13,
  parameter int unsigned FRAC_W = 8,
  parameter int unsigned PH_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_en,
  input logic              frac_en,
  input logic [RLD_W-1:0]  reload_val,
  input logic [FRAC_W-1:0] frac_step,
  input logic              pre_tick,
  input logic              frac_tick,
  input logic              src_tick,
  input logic              ovs_tick,
  input logic              bit_tick,
  input logic [RLD_W-1:0]  rld_cnt,
  input logic [PH_W-1:0]   phase
);

  p_quiet_stopped_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> (!ovs_tick && !bit_tick));

  p_pre_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pre_tick |=> !pre_tick);

  p_frac_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !frac_en |-> !frac_tick);

  p_frac_zero_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frac_step == '0) |-> !frac_tick);

  p_ovs_on_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovs_tick |-> src_tick);

  p_reload_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovs_tick |=> (rld_cnt == $past(reload_val)));

  p_bit_on_ovs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> ovs_tick);

  p_phase_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (phase == '0));

  p_restart_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(run_en) && $past(rst_n)) |-> (rld_cnt == $past(reload_val)));

endmodule

bind sbg_baud_gen sbg_baud_gen_chk #(
  .RLD_W  (RLD_W),
  .FRAC_W (FRAC_W),
  .PH_W   (PH_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_en     (run_en),
  .frac_en    (frac_en),
  .reload_val (reload_val),
  .frac_step  (frac_step),
  .pre_tick   (pre_tick),
  .frac_tick  (frac_tick),
  .src_tick   (src_tick),
  .ovs_tick   (ovs_tick),
  .bit_tick   (bit_tick),
  .rld_cnt    (rld_cnt),
  .phase      (phase)
);

// File: tb/sbg_baud_gen_tb.sv
module sbg_baud_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic        pre_sel = 1'b0;
  logic        frac_en = 1'b0;
  logic [12:0] reload_val = '0;
  logic [7:0]  frac_step = '0;
  logic        ovs_tick;
  logic        bit_tick;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  sbg_baud_gen u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .pre_sel    (pre_sel),
    .frac_en    (frac_en),
    .reload_val (reload_val),
    .frac_step  (frac_step),
    .ovs_tick   (ovs_tick),
    .bit_tick   (bit_tick)
  );

  // Source ticks seen by the end of run cycle k (R2, R4).
  function automatic int src_count(int k, bit psel, bit fen, int step);
    if (fen) return (k * step) / 256;
    return k / (psel ? 3 : 2);
  endfunction

  // Oversample strobes completed by the end of run cycle k (R5).
  function automatic int ovs_count(int k, bit psel, bit fen, int step, int n);
    return src_count(k, psel, fen, step) / (n + 1);
  endfunction

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual ovs,bit=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Stop for stop_cyc cycles, then run a constant configuration for len cycles.
  task automatic segment(bit psel, bit fen, int n, int step, int len, int stop_cyc);
    for (int s = 0; s < stop_cyc; s++) begin
      @(posedge clk); #1;
      run_en = 1'b0; pre_sel = psel; frac_en = fen;
      reload_val = 13'(n); frac_step = 8'(step);
      @(negedge clk);
      check("R1", {ovs_tick, bit_tick}, 2'b00);
    end
    for (int k = 1; k <= len; k++) begin
      int m0, m1;
      bit eo, eb;
      @(posedge clk); #1;
      run_en = 1'b1;
      // R3: the prescaler select must not matter in fractional mode.
      if (fen) pre_sel = 1'($urandom);
      @(negedge clk);
      m0 = ovs_count(k - 1, psel, fen, step, n);
      m1 = ovs_count(k, psel, fen, step, n);
      eo = (m1 != m0);
      eb = eo && (m1 % 16 == 0);
      if (fen) check("R3 R4 R5 R7 R8 R9", {ovs_tick, bit_tick}, {eo, eb});
      else     check("R2 R5 R7 R8 R9", {ovs_tick, bit_tick}, {eo, eb});
    end
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    // R10: reset holds the strobes low.
    repeat (3) begin
      @(negedge clk);
      check("R10", {ovs_tick, bit_tick}, 2'b00);
    end
    @(posedge clk); #1; rst_n = 1'b1;

    // Directed corner cases.
    segment(1'b0, 1'b0, 0, 0, 80, 2);      // /2, N=0
    segment(1'b1, 1'b0, 0, 0, 80, 1);      // /3, N=0
    segment(1'b0, 1'b1, 0, 255, 80, 1);    // near full-rate fraction
    segment(1'b0, 1'b1, 1, 128, 200, 1);   // half rate fraction
    segment(1'b1, 1'b1, 0, 0, 60, 1);      // R4: step 0 never ticks
    segment(1'b1, 1'b0, 8191, 0, 120, 1);  // largest reload, no strobe yet
    segment(1'b0, 1'b0, 3, 0, 37, 1);      // stopped mid-period, R9 restart
    segment(1'b0, 1'b0, 3, 0, 150, 1);

    // R6: reload change mid-period; N=9 on /2 then 2 written in cycle 5.
    for (int s = 0; s < 2; s++) begin
      @(posedge clk); #1;
      run_en = 1'b0; pre_sel = 1'b0; frac_en = 1'b0; reload_val = 13'd9;
    end
    for (int k = 1; k <= 40; k++) begin
      bit eo;
      @(posedge clk); #1;
      run_en = 1'b1;
      if (k == 5) reload_val = 13'd2;
      @(negedge clk);
      eo = (k == 20) || (k == 26) || (k == 32) || (k == 38);
      check("R6", {ovs_tick, bit_tick}, {eo, 1'b0});
    end

    // Random configurations.
    for (int i = 0; i < 30; i++) begin
      bit psel = 1'($urandom);
      bit fen  = 1'($urandom);
      int n    = int'($urandom % 8);
      int step = int'($urandom % 256);
      int len  = 100 + int'($urandom % 500);
      int stp  = 1 + int'($urandom % 3);
      segment(psel, fen, n, step, len, stp);
    end

    @(posedge clk); #1; run_en = 1'b0;
    @(negedge clk);
    check("R1", {ovs_tick, bit_tick}, 2'b00);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule